// File: doc/BRIEF.md
# I2C Memory Slave Controller

This block is the serial front end of a small byte-wide non-volatile memory that is reached over a two-wire I2C bus. It samples SCL and SDA on the system clock and finds START and STOP conditions. It accepts a one-byte device select. When that byte matches, it runs a word pointer that advances by itself after every byte, and it serves write bursts and three kinds of read: from the current pointer, from an address set by a dummy write followed by a repeated START, and sequential reads with no limit on length. It never drives SDA high. It only pulls the line low through an enable, for its acknowledge bits and for read data.

Each accepted data byte goes out to a write sequencer as a one-cycle strobe with its address. A STOP after a write burst sends a separate commit pulse, which starts the sequencer's program cycle. The sequencer reports that cycle back through a busy input, and the slave ignores its own address while busy is high. Read data comes from the memory array through an address/data port whose data is sampled only on SCL falling edges. With write protection on, data bytes aimed at the upper half of the array are refused. The pointer holds its page bits and never carries out of its 256-byte page.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset the SDA pull-down enable is off, and neither the write strobe nor the commit pulse is active.
- R2: The first byte after a START is taken MSB first with this layout: bits 7..4 are the device type, bits 3..1 are the chip/page field (bit 3 lowest-numbered as A2, bit 1 as A0), and bit 0 is the direction (1 = read, 0 = write). The slave acknowledges only when bits 7..4 equal 1010 and every field bit that is not a page bit equals its `pin_chip` input (`pin_chip[0]` is compared with the lowest such bit). Otherwise it stays silent until the next START.
- R3: After a write select, the next byte loads the low 8 bits of the pointer and is acknowledged. Each following data byte is acknowledged and presented once on `wr_en`/`wr_addr`/`wr_data` at the current pointer, and the pointer then advances.
- R4: The lowest ADDR_W-8 bits of the field (starting at bit 1) become the pointer's page bits on every matched select. Only the low 8 bits of the pointer ever advance, so 0x1FF is followed by 0x100 and 0x0FF by 0x000.
- R5: A write select and a word-address byte, followed by a repeated START and a read select, return the byte stored at that word address in the selected page.
- R6: A read select with no word-address byte begins at the current pointer. The pointer advances after every byte sent, and a read continues for as long as the master keeps acknowledging.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next START.
- R8: While `busy` is high, the device select byte is not acknowledged.
- R9: With `wp` high, a data byte whose target has the pointer MSB set is not acknowledged and is not written. The select and word-address bytes are still acknowledged, and writes to the lower half proceed.
- R10: `wr_commit` pulses for one cycle on a STOP if at least one data byte was accepted since the previous STOP. It does not pulse otherwise, and never in the same cycle as `wr_en`.
- R11: A repeated START partway through a byte discards the partial byte and restarts device selection. A STOP partway through a byte discards the partial byte, and no write takes place.
- R12: The SDA enable changes only while SCL is low. An acknowledge is held low through the whole high phase of the ninth clock, and read bits are placed after SCL falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| pin_chip | input | PIN_W (3-(ADDR_W-8)) | Strapped chip-select bits compared with the non-page field bits |
| wp | input | 1 | Write protect for the upper half of the array |
| busy | input | 1 | Write sequencer is programming; no select is acknowledged |
| rd_addr | output | ADDR_W | Word pointer, used as the array read address |
| rd_data | input | 8 | Array byte at `rd_addr` |
| wr_en | output | 1 | One-cycle strobe for an accepted data byte |
| wr_addr | output | ADDR_W | Target address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_commit | output | 1 | One-cycle pulse at a STOP that ends a write burst |

## Verification
The properties assume that both SCL phases last several system clocks longer than the two-flop synchroniser delay, so that the slave's SDA updates, made a few cycles after a detected fall, still see a low raw SCL. They also assume that `busy` is raised only while no write burst is in progress. The bench's master keeps each SCL phase at sixteen system clocks, changes its own SDA only some cycles after SCL falls, and raises `busy` or `wp` only between transactions. The bus is modelled as a wired-AND of the master's drive and the slave's enable, so START and STOP can never collide with a slave-held low level.

// File: rtl/i2c_mem_pkg.sv
`timescale 1ns/1ps
// Shared types for the I2C memory slave.
// Assumes: byte-wide transfers, fixed device type nibble.
package i2c_mem_pkg;

    // Fixed device type nibble expected in bits 7..4 of the select byte.
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Bus-side sequencing of the slave.
    typedef enum logic [2:0] {
        ST_IDLE,     // not addressed, waiting for START
        ST_RX,       // shifting in a byte on SCL rising edges
        ST_ACK_ON,   // byte complete, wait SCL fall to drive ACK
        ST_ACK_OFF,  // ACK driven, wait SCL fall to release
        ST_TX,       // shifting out a read byte on SCL falling edges
        ST_MACK      // sampling the master's acknowledge
    } slv_state_t;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        BK_SELECT,   // device select byte
        BK_WORD,     // word-address byte
        BK_DATA      // write data byte
    } byte_kind_t;

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
// Line synchroniser and bus-condition detector.
// Brings SCL and SDA into the clk domain through two flops each and
// flags SCL edges and START/STOP conditions for one cycle.
// Assumes: clk is several times faster than SCL; lines idle high.
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_m, scl_s, scl_q;
    logic sda_m, sda_q;

    // Two-flop synchronisers plus one history stage per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            scl_s <= 1'b1;
            scl_q <= 1'b1;
            sda_m <= 1'b1;
            sda_s <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_m <= scl_in;
            scl_s <= scl_m;
            scl_q <= scl_s;
            sda_m <= sda_in;
            sda_s <= sda_m;
            sda_q <= sda_s;
        end
    end

    // Edge and condition flags derived from current and previous samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_dev_match.sv
`timescale 1ns/1ps
// Device select comparator.
// Compares the type nibble and the non-page chip bits of a select byte.
// Assumes: PAGE_BITS in 0..2 so at least one chip pin remains.
module i2c_dev_match
    import i2c_mem_pkg::*;
#(
    parameter  int PAGE_BITS = 1,
    localparam int PIN_W     = 3 - PAGE_BITS
) (
    input  logic [7:PAGE_BITS+1] sel_bits,
    input  logic [PIN_W-1:0]     pin_chip,
    output logic                 hit
);

    logic [PIN_W-1:0] pin_eq;

    // One comparator per strapped chip pin.
    for (genvar g = 0; g < PIN_W; g++) begin : g_pin
        assign pin_eq[g] = (sel_bits[PAGE_BITS+1+g] == pin_chip[g]);
    end

    // Select matches when type and all strapped bits agree.
    assign hit = (sel_bits[7:4] == DEV_TYPE) && (&pin_eq);

endmodule

// File: rtl/i2c_word_ptr.sv
`timescale 1ns/1ps
// Word pointer with page-locked increment.
// Low 8 bits load from the word-address byte and count; page bits load
// from the select byte and never change on increment.
// Assumes: ADDR_W in 8..10.
module i2c_word_ptr #(
    parameter  int ADDR_W    = 9,
    localparam int PAGE_BITS = ADDR_W - 8,
    localparam int PVW       = (PAGE_BITS > 0) ? PAGE_BITS : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_ld,
    input  logic [PVW-1:0]    page_val,
    input  logic              low_ld,
    input  logic [7:0]        low_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] ptr
);

    logic [7:0] lo;

    // Low byte: load wins over increment; wraps within the page.
    always_ff @(posedge clk) begin
        if (!rst_n)      lo <= '0;
        else if (low_ld) lo <= low_val;
        else if (inc)    lo <= lo + 8'd1;
    end

    if (PAGE_BITS > 0) begin : g_paged
        logic [PAGE_BITS-1:0] hi;
        // Page bits: taken from a matched select byte only.
        always_ff @(posedge clk) begin
            if (!rst_n)       hi <= '0;
            else if (page_ld) hi <= page_val;
        end
        assign ptr = {hi, lo};
    end else begin : g_flat
        assign ptr = lo;
    end

endmodule

// File: rtl/i2c_mem_slave.sv
`timescale 1ns/1ps
// I2C memory slave controller (top).
// Decodes select, word-address and data bytes, drives ACK and read data
// through an open-drain enable, feeds a write sequencer and reads the
// array through an address/data port.
// Assumes: rd_data is valid for rd_addr by the next SCL falling edge;
// busy is raised by the sequencer only after wr_commit.
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter  int ADDR_W    = 9,
    localparam int PAGE_BITS = ADDR_W - 8,
    localparam int PIN_W     = 3 - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [PIN_W-1:0]  pin_chip,
    input  logic              wp,
    input  logic              busy,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);

    localparam int PVW = (PAGE_BITS > 0) ? PAGE_BITS : 1;

    logic        sda_s, scl_rise, scl_fall, start_det, stop_det;
    slv_state_t  state;
    byte_kind_t  kind;
    logic [2:0]  bit_cnt;
    logic [6:0]  rx_sr;
    logic [7:0]  tx_sr;
    logic [7:0]  rx_byte;
    logic        drive_low, ack_ok, to_tx, m_ack, wrote;
    logic        dev_hit, accept, rx_done, tx_last;
    logic        page_ld, low_ld, ptr_inc;
    logic [ADDR_W-1:0] ptr;

    i2c_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign rx_byte = {rx_sr, sda_s};

    i2c_dev_match #(.PAGE_BITS(PAGE_BITS)) u_match (
        .sel_bits (rx_byte[7:PAGE_BITS+1]),
        .pin_chip (pin_chip),
        .hit      (dev_hit)
    );

    i2c_word_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .page_ld  (page_ld),
        .page_val (rx_byte[PVW:1]),
        .low_ld   (low_ld),
        .low_val  (rx_byte),
        .inc      (ptr_inc),
        .ptr      (ptr)
    );

    // Byte-boundary events and the accept decision for a finished byte.
    always_comb begin
        rx_done = (state == ST_RX) && scl_rise && (bit_cnt == 3'd7);
        tx_last = (state == ST_TX) && scl_fall && (bit_cnt == 3'd7);
        case (kind)
            BK_SELECT: accept = dev_hit && !busy;
            BK_WORD:   accept = 1'b1;
            default:   accept = !(wp && ptr[ADDR_W-1]);
        endcase
        page_ld = rx_done && (kind == BK_SELECT) && accept;
        low_ld  = rx_done && (kind == BK_WORD);
        ptr_inc = (rx_done && (kind == BK_DATA) && accept) || tx_last;
    end

    // Bus sequencing, shift registers, SDA enable and sequencer strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind      <= BK_SELECT;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            drive_low <= 1'b0;
            ack_ok    <= 1'b0;
            to_tx     <= 1'b0;
            m_ack     <= 1'b0;
            wrote     <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_en     <= 1'b0;
            wr_commit <= 1'b0;
            if (start_det) begin
                state     <= ST_RX;
                kind      <= BK_SELECT;
                bit_cnt   <= '0;
                drive_low <= 1'b0;
            end else if (stop_det) begin
                state     <= ST_IDLE;
                drive_low <= 1'b0;
                if (wrote) begin
                    wr_commit <= 1'b1;
                    wrote     <= 1'b0;
                end
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sr   <= rx_byte[6:0];
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) begin
                                ack_ok <= accept;
                                to_tx  <= (kind == BK_SELECT) && rx_byte[0];
                                state  <= ST_ACK_ON;
                                if (kind == BK_SELECT) kind <= BK_WORD;
                                else                   kind <= BK_DATA;
                                if ((kind == BK_DATA) && accept) begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= rx_byte;
                                    wrote   <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_ACK_ON: begin
                        if (scl_fall) begin
                            if (ack_ok) begin
                                drive_low <= 1'b1;
                                state     <= ST_ACK_OFF;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK_OFF: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (to_tx) begin
                                tx_sr     <= rd_data;
                                drive_low <= ~rd_data[7];
                                state     <= ST_TX;
                            end else begin
                                drive_low <= 1'b0;
                                state     <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 3'd7) begin
                                drive_low <= 1'b0;
                                state     <= ST_MACK;
                            end else begin
                                tx_sr     <= {tx_sr[6:0], 1'b0};
                                drive_low <= ~tx_sr[6];
                                bit_cnt   <= bit_cnt + 3'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (m_ack) begin
                                bit_cnt   <= '0;
                                tx_sr     <= rd_data;
                                drive_low <= ~rd_data[7];
                                state     <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe  = drive_low;
    assign rd_addr = ptr;

endmodule

// File: rtl/i2c_mem_slave_chk.sv
`timescale 1ns/1ps
// Property checker for i2c_mem_slave, attached by bind.
// Assumes: SCL phases last longer than the synchroniser delay.
module i2c_mem_slave_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_in,
    input logic              sda_oe,
    input logic              wp,
    input logic              busy,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_commit
);

    // R12: the pull-down enable moves only while SCL is low.
    a_r12_sda_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_in);

    // R9: no strobe into the protected upper half.
    a_r9_wp_blocks_upper: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !(wp && wr_addr[ADDR_W-1]));

    // R4: after a strobe the pointer sits one further on, same page.
    a_r4_ptr_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((rd_addr[7:0] == wr_addr[7:0] + 8'd1) &&
                   ((rd_addr >> 8) == (wr_addr >> 8))));

    // R10: commit and data strobe never coincide.
    a_r10_commit_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_commit));

    // R8: no data strobe while the sequencer is busy.
    a_r8_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy);

endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .wp        (wp),
    .busy      (busy),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_commit (wr_commit)
);

// File: tb/i2c_mem_slave_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected writes, the monitor pops
// them on each strobe; read data is compared with a bench-side image.
module i2c_mem_slave_tb_top;

    localparam int ADDR_W = 9;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int H      = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [1:0] pin_chip = 2'b10;
    logic wp = 1'b0;
    logic busy = 1'b0;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic wr_en, wr_commit;

    logic [7:0] ram     [DEPTH];
    logic [7:0] exp_mem [DEPTH];

    int n_chk = 0;
    int n_err = 0;
    int commits = 0;
    int exp_commits = 0;

    typedef struct { int a; int d; string req; } wr_item_t;
    wr_item_t exp_q[$];
    typedef logic [7:0] bq_t[$];

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;
    assign rd_data = ram[rd_addr];

    i2c_mem_slave #(.ADDR_W(ADDR_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_bus),
        .sda_oe    (sda_oe),
        .pin_chip  (pin_chip),
        .wp        (wp),
        .busy      (busy),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] seed(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] dev(input int page, input bit rd);
        return {4'b1010, 2'b10, 1'(page), rd};
    endfunction

    // Monitor: array model update, scoreboard pop, commit counting.
    always @(negedge clk) begin
        if (wr_commit) commits++;
        if (wr_en) begin
            ram[wr_addr] = wr_data;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected write", int'(wr_addr), -1);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk(int'(wr_addr) == it.a, it.req, int'(wr_addr), it.a);
                chk(int'(wr_data) == it.d, it.req, int'(wr_data), it.d);
            end
        end
    end

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; hw(H);
        sda_m = 1'b0; hw(H);
        scl_m = 1'b0; hw(4);
    endtask

    task automatic bus_rstart();
        hw(4); sda_m = 1'b1; hw(H);
        scl_m = 1'b1; hw(H);
        sda_m = 1'b0; hw(H);
        scl_m = 1'b0; hw(4);
    endtask

    task automatic bus_stop();
        hw(4); sda_m = 1'b0; hw(H);
        scl_m = 1'b1; hw(H);
        sda_m = 1'b1; hw(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            hw(4); sda_m = b[i]; hw(H - 4);
            scl_m = 1'b1; hw(H);
            scl_m = 1'b0;
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        hw(4); sda_m = 1'b1; hw(H - 4);
        scl_m = 1'b1; hw(H / 2);
        ack = (sda_bus == 1'b0);
        hw(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] b);
        hw(4); sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw(H);
            scl_m = 1'b1; hw(H / 2);
            b[i] = sda_bus;
            hw(H / 2);
            scl_m = 1'b0;
        end
        hw(4); sda_m = give_ack ? 1'b0 : 1'b1; hw(H - 4);
        scl_m = 1'b1; hw(H);
        scl_m = 1'b0; hw(4);
        sda_m = 1'b1;
    endtask

    task automatic expect_write(input int a, input int d, input string req);
        wr_item_t it;
        it.a = a; it.d = d; it.req = req;
        exp_q.push_back(it);
        exp_mem[a] = 8'(d);
    endtask

    // Full write burst with acknowledge checks and a commit check.
    task automatic write_seq(input int page, input int wa, input bq_t data, input string req);
        bit ack;
        bus_start();
        wr_byte(dev(page, 1'b0), ack); chk(ack, "R2 select ack", ack, 1);
        wr_byte(8'(wa), ack);          chk(ack, "R3 word ack", ack, 1);
        foreach (data[i]) begin
            expect_write(page * 256 + ((wa + i) & 255), data[i], req);
            wr_byte(data[i], ack);
            chk(ack, "R3 data ack", ack, 1);
        end
        bus_stop();
        exp_commits++;
        chk(commits == exp_commits, "R10 commit after write", commits, exp_commits);
    endtask

    // Dummy write then repeated START and a sequential read.
    task automatic rand_read(input int page, input int wa, input int n, input string req);
        bit ack;
        logic [7:0] b;
        bus_start();
        wr_byte(dev(page, 1'b0), ack); chk(ack, "R5 select ack", ack, 1);
        wr_byte(8'(wa), ack);          chk(ack, "R5 word ack", ack, 1);
        bus_rstart();
        wr_byte(dev(page, 1'b1), ack); chk(ack, "R5 read select ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            int a;
            a = page * 256 + ((wa + i) & 255);
            rd_byte(i < n - 1, b);
            chk(b == exp_mem[a], req, b, exp_mem[a]);
        end
        bus_stop();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        hw(150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] b;
        for (int i = 0; i < DEPTH; i++) begin
            ram[i] = seed(i);
            exp_mem[i] = seed(i);
        end
        hw(5);
        rst_n = 1'b1;
        hw(5);
        chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
        chk(wr_en == 1'b0, "R1 no strobe", wr_en, 0);
        chk(wr_commit == 1'b0, "R1 no commit", wr_commit, 0);

        // R3: burst in page 0
        write_seq(0, 8'h10, '{8'h11, 8'h22, 8'h33}, "R3 write burst");
        // R4: wrap inside page 1
        write_seq(1, 8'hFE, '{8'hA1, 8'hA2, 8'hA3}, "R4 page wrap write");

        // R5: random read of the first burst; no commit for reads (R10)
        rand_read(0, 8'h10, 3, "R5 random read");
        chk(commits == exp_commits, "R10 no commit after read", commits, exp_commits);

        // R6: current-address read continues at 0x013; R7 release after NACK
        bus_start();
        wr_byte(dev(0, 1'b1), ack); chk(ack, "R6 select ack", ack, 1);
        rd_byte(1'b0, b);
        chk(b == exp_mem[9'h013], "R6 current address read", b, exp_mem[9'h013]);
        hw(H);
        chk(sda_oe == 1'b0, "R7 released after NACK", sda_oe, 0);
        scl_m = 1'b1; hw(H / 2);
        chk(sda_bus == 1'b1, "R7 no further data", sda_bus, 1);
        hw(H / 2); scl_m = 1'b0;
        bus_stop();

        // R6/R4: sequential read across the page edge
        rand_read(1, 8'hFF, 2, "R6 sequential read with wrap");

        // R2: wrong type nibble and wrong chip pin
        bus_start();
        wr_byte(8'hB8, ack); chk(!ack, "R2 wrong type", ack, 0);
        bus_stop();
        bus_start();
        wr_byte(8'hA0, ack); chk(!ack, "R2 wrong chip pin", ack, 0);
        bus_stop();

        // R8: busy silences the slave
        busy = 1'b1;
        bus_start();
        wr_byte(dev(0, 1'b0), ack); chk(!ack, "R8 write select busy", ack, 0);
        bus_stop();
        bus_start();
        wr_byte(dev(0, 1'b1), ack); chk(!ack, "R8 read select busy", ack, 0);
        bus_stop();
        busy = 1'b0;

        // R9: upper half refused, lower half accepted
        wp = 1'b1;
        bus_start();
        wr_byte(dev(1, 1'b0), ack); chk(ack, "R9 select ack", ack, 1);
        wr_byte(8'h20, ack);        chk(ack, "R9 word ack", ack, 1);
        wr_byte(8'h77, ack);        chk(!ack, "R9 protected data nack", ack, 0);
        bus_stop();
        chk(commits == exp_commits, "R10 no commit after refusal", commits, exp_commits);
        write_seq(0, 8'h30, '{8'h44}, "R9 lower half write");
        wp = 1'b0;
        rand_read(1, 8'h20, 1, "R9 protected byte unchanged");

        // R11: repeated START mid-byte, then read from unchanged pointer
        bus_start();
        wr_byte(dev(0, 1'b0), ack); chk(ack, "R11 select ack", ack, 1);
        wr_byte(8'h40, ack);        chk(ack, "R11 word ack", ack, 1);
        send_bits(8'hFF, 4);
        bus_rstart();
        wr_byte(dev(0, 1'b1), ack); chk(ack, "R11 reselect ack", ack, 1);
        rd_byte(1'b0, b);
        chk(b == exp_mem[9'h040], "R11 pointer not advanced", b, exp_mem[9'h040]);
        bus_stop();

        // R11: STOP mid-byte writes nothing
        bus_start();
        wr_byte(dev(0, 1'b0), ack); chk(ack, "R11 select ack", ack, 1);
        wr_byte(8'h50, ack);        chk(ack, "R11 word ack", ack, 1);
        send_bits(8'h00, 5);
        bus_stop();
        chk(commits == exp_commits, "R11 no commit after partial", commits, exp_commits);
        rand_read(0, 8'h50, 1, "R11 partial byte discarded");

        hw(10);
        chk(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule